// File: doc/BRIEF.md
# Programmable Management Bus Clock Generator

This block derives a slow serial management bus clock from a 25 MHz system clock. A fixed divide-by-ten prescaler yields a 2.5 MHz event rate; a linear stage then divides by (M+1) and a binary stage by 2^(N+1). The result is a bus clock at 2500 kHz / ((M+1)·2^(N+1)), which spans 1.25 MHz down to a few hundred hertz. Because the two factors multiply, only a discontinuous set of rates can be reached. A target ratio of exactly 250, for example, has no (M, N) pair, and the nearest usable setting is chosen instead.

The clock is produced as a registered square-wave level with a 50% duty cycle. Two single-cycle strobes mark its rising and falling edges, so that the surrounding serial logic can shift data without a second clock domain. One configuration word carries an enable bit and both factors. Settings written while the clock runs are held back until the current period ends, so no shortened pulse ever appears on the bus.

Top module: `mgmt_clk_gen`

## Requirements
- R1: The configuration word has the enable in bit 15, M in bits 11:8 and N in bits 2:0. With enable set, each half-period lasts H = 10·(M+1)·2^N system cycles. The first rise of the clock comes H cycles after the first cycle in which enable is sampled high.
- R2: The high half and the low half of every period are both exactly H cycles long, so the duty cycle is 50%.
- R3: M=0, N=0 gives the fastest rate, with H = 10 (1.25 MHz from 25 MHz). M=0xE, N=3 gives H = 1200 (about 10.4 kHz). M=0xF, N=7 gives the slowest rate, with H = 20480.
- R4: While the enable bit is 0, the clock output is low and neither edge strobe fires, from the cycle after enable is sampled low.
- R5: During reset and right after it, the clock output and both strobes are 0.
- R6: The rise strobe is high only in the first cycle in which the clock is 1. The fall strobe is high only in the first cycle in which the clock is 0 after being high. The two strobes are never high together.
- R7: M and N written while the clock runs take effect only from the next falling edge. The period in progress finishes with the old settings, so no high phase is shorter than the minimum half-period.
- R8: Clearing enable while the clock is high forces it low in the next cycle without a fall strobe. Setting enable again restarts with a full low half of H cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz system clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 16 | Configuration: enable bit 15, M bits 11:8, N bits 2:0 |
| sclk | output | 1 | Registered bus clock level |
| rise_tick | output | 1 | One-cycle strobe in the first cycle sclk is high |
| fall_tick | output | 1 | One-cycle strobe in the first cycle sclk is low again |

## Verification
Every output is registered after the divider chain, so a rise is due exactly H sampling points after the enable is driven. Each later edge is due H points after the previous strobe was observed. The bench drives and samples on the falling clock edge and counts those points from the moment of stimulus up to the strobe, then compares the count with the value the requirements predict. The disable check samples at the very next point, one register after the change.

// File: rtl/sgen_pkg.sv
package sgen_pkg;
  localparam int SGEN_PRE_DIV = 10;
  localparam int SGEN_M_W     = 4;
  localparam int SGEN_N_W     = 3;

  // width of the binary stage counter: largest half count is 2^(2^N_W-1)-1
  function automatic int sgen_bin_width(input int n_w);
    return (1 << n_w) - 1;
  endfunction
endpackage

// File: rtl/sgen_prescale.sv
module sgen_prescale #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst || !run)    cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                cnt <= cnt + 1'b1;
      end
      assign tick = run && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/sgen_lindiv.sv
module sgen_lindiv #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic         tick
);
  logic [W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst || !run)  cnt <= '0;
    else if (step)    cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
  end
  assign tick = run && step && (cnt == lim);
endmodule

// File: rtl/sgen_bindiv.sv
module sgen_bindiv import sgen_pkg::*; #(
  parameter int NW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          step,
  input  logic [NW-1:0] n_sel,
  output logic          toggle
);
  localparam int CW = sgen_bin_width(NW);
  logic [CW-1:0] cnt;
  logic [CW-1:0] term;

  assign term = CW'((64'd1 << n_sel) - 64'd1);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (step)   cnt <= (cnt == term) ? '0 : cnt + 1'b1;
  end
  assign toggle = run && step && (cnt == term);
endmodule

// File: rtl/mgmt_clk_gen.sv
module mgmt_clk_gen import sgen_pkg::*; #(
  parameter int PRE_DIV = SGEN_PRE_DIV,
  parameter int M_W     = SGEN_M_W,
  parameter int N_W     = SGEN_N_W,
  parameter int CFG_W   = 16,
  parameter int EN_BIT  = 15,
  parameter int M_LSB   = 8,
  parameter int N_LSB   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             sclk,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic           en;
  logic [M_W-1:0] cfg_m;
  logic [N_W-1:0] cfg_n;
  logic           unused_cfg_fold;

  assign en              = cfg_word[EN_BIT];
  assign cfg_m           = cfg_word[M_LSB +: M_W];
  assign cfg_n           = cfg_word[N_LSB +: N_W];
  assign unused_cfg_fold = ^cfg_word;

  logic           run_q;
  logic [M_W-1:0] m_act;
  logic [N_W-1:0] n_act;
  logic           sclk_q, rise_q, fall_q;
  logic           pre_tick, lin_tick, half_toggle, boundary;

  sgen_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .run(en), .tick(pre_tick)
  );

  sgen_lindiv #(.W(M_W)) u_lin (
    .clk(clk), .rst(rst), .run(en), .step(pre_tick), .lim(m_act), .tick(lin_tick)
  );

  sgen_bindiv #(.NW(N_W)) u_bin (
    .clk(clk), .rst(rst), .run(en), .step(lin_tick), .n_sel(n_act), .toggle(half_toggle)
  );

  // end of a full period: the falling toggle
  assign boundary = half_toggle && sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      m_act  <= '0;
      n_act  <= '0;
      sclk_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      run_q <= en;
      // settings follow the word while idle, then only at period ends
      if (!run_q || boundary) begin
        m_act <= cfg_m;
        n_act <= cfg_n;
      end
      if (!en) begin
        sclk_q <= 1'b0;
        rise_q <= 1'b0;
        fall_q <= 1'b0;
      end else begin
        rise_q <= half_toggle && !sclk_q;
        fall_q <= boundary;
        if (half_toggle) sclk_q <= !sclk_q;
      end
    end
  end

  assign sclk      = sclk_q;
  assign rise_tick = rise_q;
  assign fall_tick = fall_q;
endmodule

// File: rtl/sgen_checker.sv
module sgen_checker #(
  parameter int MIN_HALF = 10
) (
  input logic clk,
  input logic rst,
  input logic cfg_en,
  input logic sclk,
  input logic rise_tick,
  input logic fall_tick
);
  logic [31:0] hi_len;
  always_ff @(posedge clk) begin
    if (rst)       hi_len <= '0;
    else if (sclk) hi_len <= hi_len + 1;
    else           hi_len <= '0;
  end

  assert_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> (!sclk && !rise_tick && !fall_tick));

  assert_rise_edge_R6: assert property (@(posedge clk) disable iff (rst)
    rise_tick |-> (sclk && !$past(sclk)));

  assert_fall_edge_R6: assert property (@(posedge clk) disable iff (rst)
    fall_tick |-> (!sclk && $past(sclk)));

  assert_tick_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(rise_tick && fall_tick));

  assert_single_rise_R6: assert property (@(posedge clk) disable iff (rst)
    rise_tick |=> !rise_tick);

  assert_rise_flagged_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> rise_tick);

  assert_no_runt_R7: assert property (@(posedge clk) disable iff (rst)
    fall_tick |-> (hi_len >= MIN_HALF));
endmodule

bind mgmt_clk_gen sgen_checker #(.MIN_HALF(PRE_DIV)) u_sgen_chk (
  .clk(clk), .rst(rst), .cfg_en(cfg_word[EN_BIT]),
  .sclk(sclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
);

// File: tb/test_mgmt_clk_gen.sv
module test_mgmt_clk_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_word = '0;
  logic        sclk, rise_tick, fall_tick;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  mgmt_clk_gen i_mgmt_clk_gen (
    .clk(clk), .rst(rst), .cfg_word(cfg_word),
    .sclk(sclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  always #2 clk = ~clk;

  // {M[3:0], N[2:0], expected half-period[19:0]}
  localparam logic [26:0] VEC [7] = '{
    {4'h0, 3'd0, 20'd10},
    {4'hE, 3'd3, 20'd1200},
    {4'h3, 3'd1, 20'd80},
    {4'hF, 3'd0, 20'd160},
    {4'h0, 3'd7, 20'd1280},
    {4'h7, 3'd2, 20'd320},
    {4'h5, 3'd5, 20'd1920}
  };

  function automatic logic [15:0] word(input bit en, input logic [3:0] m, input logic [2:0] n);
    return {en, 3'b000, m, 5'b00000, n};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_edge(input bit want_rise, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(want_rise ? rise_tick : fall_tick) && n < 50000);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int n;
    int bad;
    // R5: reset state
    repeat (5) @(negedge clk);
    chk(!sclk && !rise_tick && !fall_tick, "R5 in reset", {sclk, rise_tick, fall_tick}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!sclk && !rise_tick && !fall_tick, "R5 after reset", {sclk, rise_tick, fall_tick}, 0);

    // R4: disabled with fastest factors loaded, nothing toggles
    cfg_word = word(1'b0, 4'h0, 3'd0);
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sclk || rise_tick || fall_tick) bad++;
    end
    chk(bad == 0, "R4 idle while disabled", bad, 0);

    // table walk: R1 first rise, R2 halves, R3 specific rates, R6 strobe alignment
    for (int v = 0; v < 7; v++) begin
      int h;
      h = int'(VEC[v][19:0]);
      cfg_word = word(1'b0, VEC[v][26:23], VEC[v][22:20]);
      @(negedge clk);
      cfg_word = word(1'b1, VEC[v][26:23], VEC[v][22:20]);
      wait_edge(1'b1, n);
      chk(n == h, (v == 0 || v == 1) ? "R1 R3 first rise" : "R1 first rise", n, h);
      chk(sclk == 1'b1, "R6 rise strobe with high level", int'(sclk), 1);
      wait_edge(1'b0, n);
      chk(n == h, "R2 high half", n, h);
      chk(sclk == 1'b0, "R6 fall strobe with low level", int'(sclk), 0);
      wait_edge(1'b1, n);
      chk(n == h, "R2 low half", n, h);
      @(negedge clk);
      chk(!rise_tick, "R6 rise strobe one cycle", int'(rise_tick), 0);
    end

    // R7: reprogram while high; old settings finish the period
    cfg_word = word(1'b0, 4'h0, 3'd0);
    @(negedge clk);
    cfg_word = word(1'b1, 4'h0, 3'd0);
    wait_edge(1'b1, n);
    cfg_word = word(1'b1, 4'h3, 3'd0);
    wait_edge(1'b0, n);
    chk(n == 10, "R7 current high half keeps old setting", n, 10);
    wait_edge(1'b1, n);
    chk(n == 40, "R7 new low half after boundary", n, 40);
    wait_edge(1'b0, n);
    chk(n == 40, "R7 new high half", n, 40);

    // R8: drop enable mid-high, then re-enable
    cfg_word = word(1'b1, 4'h1, 3'd0);
    wait_edge(1'b1, n);
    wait_edge(1'b1, n);
    repeat (5) @(negedge clk);
    chk(sclk == 1'b1, "R8 clock high before disable", int'(sclk), 1);
    cfg_word = word(1'b0, 4'h1, 3'd0);
    @(negedge clk);
    chk(!sclk && !fall_tick, "R8 forced low without fall strobe", {sclk, fall_tick}, 0);
    cfg_word = word(1'b1, 4'h1, 3'd0);
    wait_edge(1'b1, n);
    chk(n == 20, "R8 full low half after re-enable", n, 20);

    // R3: slowest setting
    cfg_word = word(1'b0, 4'hF, 3'd7);
    @(negedge clk);
    cfg_word = word(1'b1, 4'hF, 3'd7);
    wait_edge(1'b1, n);
    chk(n == 20480, "R3 slowest first rise", n, 20480);
    wait_edge(1'b0, n);
    chk(n == 20480, "R3 slowest high half", n, 20480);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule